// File: doc/BRIEF.md
# Four-bit function-select ALU slice

A purely combinational ALU slice that combines two active-high operands under a four-bit function select and a mode input. With the mode input high it produces one of the sixteen two-input bitwise functions, each result bit depending only on the matching bits of A and B. With the mode input low it produces one of sixteen add-based functions: add, subtract, double, decrement, pass and mixed forms. Subtraction is done by adding the complement of B.

The carry input and the ripple carry output are active low. A low carry input adds one to an arithmetic result. A low carry output means a carry left the slice, which during subtraction means no borrow. Group generate and group propagate outputs, also active low, depend only on A, B and the select, so an external lookahead unit can combine several slices. An equality flag is high whenever every result bit is high. In subtract mode with no carry this is the test A == B, and the flags of several slices can be ANDed into a wider comparison.

The slice width and the internal carry network (full lookahead or ripple) are parameters. The default is a 4-bit slice with lookahead.

Top module: `alu_slice4`

## Requirements
- R1: With logic_mode_i = 1, f_o is bitwise per select code sel_i (value shown as hex): 0 ~A, 1 ~(A|B), 2 ~A&B, 3 all zeros, 4 ~(A&B), 5 ~B, 6 A^B, 7 A&~B, 8 ~A|B, 9 ~(A^B), A B, B A&B, C all ones, D A|~B, E A|B, F A.
- R2: With logic_mode_i = 1, f_o does not depend on carry_n_i.
- R3: With logic_mode_i = 0, f_o = X + Y + carry (modulo 2^WIDTH), where carry = ~carry_n_i and (X,Y) per sel_i is: 0 (A,0), 1 (A|B,0), 2 (A|~B,0), 3 (0,all ones), 4 (A,A&~B), 5 (A|B,A&~B), 6 (A,~B), 7 (A&~B,all ones), 8 (A,A&B), 9 (A,B), A (A|~B,A&B), B (A&B,all ones), C (A,A), D (A|B,A), E (A|~B,A), F (A,all ones).
- R4: The carry input is active low. carry_n_i = 1 adds nothing and carry_n_i = 0 adds exactly one. For example, sel_i = 0 in arithmetic mode gives A and A+1.
- R5: carry_n_o is the inverse of bit WIDTH of X + Y + carry in either mode, with (X,Y) as in R3. For sel_i = 6 with carry_n_i = 0, carry_n_o is low exactly when A >= B.
- R6: gen_n_o is low exactly when X + Y overflows WIDTH bits with no carry in. gen_n_o and prop_n_o do not change with carry_n_i.
- R7: The ripple carry out agrees with the group outputs: carry_n_o is low exactly when gen_n_o is low, or when prop_n_o and carry_n_i are both low.
- R8: equal_o is high exactly when all bits of f_o are high.
- R9: With logic_mode_i = 0, sel_i = 6 and carry_n_i = 1, equal_o is high exactly when A == B.
- R10: Slices chained carry_n_o to carry_n_i form a wider adder (sel 9), a subtractor (sel 6, carry_n_i low) with a borrow at the last carry_n_o, and a comparator when their equal_o outputs are ANDed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A, active high |
| b_i | input | WIDTH | Operand B, active high |
| sel_i | input | 4 | Function select code |
| logic_mode_i | input | 1 | 1 = bitwise functions, 0 = arithmetic |
| carry_n_i | input | 1 | Carry in, active low |
| f_o | output | WIDTH | Function result |
| carry_n_o | output | 1 | Ripple carry out, active low |
| prop_n_o | output | 1 | Group propagate, active low |
| gen_n_o | output | 1 | Group generate, active low |
| equal_o | output | 1 | High when every f_o bit is high |

## Verification
Two functions share every vector: the result and the carry, group and equality outputs are all formed from the same per-bit terms. The sweep over every A, B, select, mode and carry value therefore judges them together against sums computed in the bench. The carry outputs are also checked while the mode input is high, when the result ignores the carry. Group generate and propagate are compared across the two carry-input values of each vector. A chain of four slices is then judged as a 16-bit adder, subtractor and comparator, so ripple carries and the combined equality flag meet within one result.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

   localparam int SEL_W = 4;

   localparam int SEL_OR_B    = 0;
   localparam int SEL_OR_NB   = 1;
   localparam int SEL_GEN_NB  = 2;
   localparam int SEL_GEN_B   = 3;

   typedef enum logic {
      CARRY_RIPPLE    = 1'b0,
      CARRY_LOOKAHEAD = 1'b1
   } carry_style_e;

endpackage

// File: rtl/alu_operand_gen.sv
module alu_operand_gen
   import alu_slice_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic [WIDTH-1:0] prop_o,
   output logic [WIDTH-1:0] gen_o
);

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         logic b_true;
         logic b_false;
         assign b_true  = b_i[gi];
         assign b_false = ~b_i[gi];
         assign prop_o[gi] = a_i[gi]
                           | (b_true  & sel_i[SEL_OR_B])
                           | (b_false & sel_i[SEL_OR_NB]);
         assign gen_o[gi]  = (a_i[gi] & b_false & sel_i[SEL_GEN_NB])
                           | (a_i[gi] & b_true  & sel_i[SEL_GEN_B]);
      end
   endgenerate

endmodule

// File: rtl/alu_carry_net.sv
module alu_carry_net
   import alu_slice_pkg::*;
#(
   parameter int           WIDTH = 4,
   parameter carry_style_e STYLE = CARRY_LOOKAHEAD
) (
   input  logic [WIDTH-1:0] prop_i,
   input  logic [WIDTH-1:0] gen_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] carry_o,
   output logic             grp_gen_o,
   output logic             grp_prop_o,
   output logic             carry_out_o
);

   localparam int TOP = WIDTH - 1;

   function automatic logic span_carry(input logic [WIDTH-1:0] p,
                                       input logic [WIDTH-1:0] g,
                                       input logic             cin,
                                       input int               upto);
      logic acc;
      logic run;
      acc = 1'b0;
      run = 1'b1;
      for (int j = upto; j >= 0; j--) begin
         acc = acc | (run & g[j]);
         run = run & p[j];
      end
      return acc | (run & cin);
   endfunction

   assign grp_prop_o = &prop_i;

   generate
      if (STYLE == CARRY_LOOKAHEAD) begin : g_lookahead
         always_comb begin
            carry_o[0] = carry_i;
            for (int i = 1; i < WIDTH; i++) begin
               carry_o[i] = span_carry(prop_i, gen_i, carry_i, i - 1);
            end
         end
         assign grp_gen_o   = span_carry(prop_i, gen_i, 1'b0, TOP);
         assign carry_out_o = grp_gen_o | (grp_prop_o & carry_i);
      end else begin : g_ripple
         logic [WIDTH:0] chain;
         logic [WIDTH:0] chain0;
         assign chain[0]  = carry_i;
         assign chain0[0] = 1'b0;
         genvar ri;
         for (ri = 0; ri < WIDTH; ri++) begin : g_stage
            assign chain[ri+1]  = gen_i[ri] | (prop_i[ri] & chain[ri]);
            assign chain0[ri+1] = gen_i[ri] | (prop_i[ri] & chain0[ri]);
         end
         assign carry_o     = chain[WIDTH-1:0];
         assign grp_gen_o   = chain0[WIDTH];
         assign carry_out_o = chain[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/alu_result.sv
module alu_result #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] prop_i,
   input  logic [WIDTH-1:0] gen_i,
   input  logic [WIDTH-1:0] carry_i,
   input  logic             logic_mode_i,
   output logic [WIDTH-1:0] f_o,
   output logic             all_ones_o
);

   logic [WIDTH-1:0] half_sum;
   logic [WIDTH-1:0] flip;

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         assign half_sum[gi] = prop_i[gi] & ~gen_i[gi];
         assign flip[gi]     = logic_mode_i | carry_i[gi];
         assign f_o[gi]      = half_sum[gi] ^ flip[gi];
      end
   endgenerate

   assign all_ones_o = &f_o;

endmodule

// File: rtl/alu_slice4.sv
module alu_slice4
   import alu_slice_pkg::*;
#(
   parameter int           WIDTH       = 4,
   parameter carry_style_e CARRY_STYLE = CARRY_LOOKAHEAD
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       sel_i,
   input  logic             logic_mode_i,
   input  logic             carry_n_i,
   output logic [WIDTH-1:0] f_o,
   output logic             carry_n_o,
   output logic             prop_n_o,
   output logic             gen_n_o,
   output logic             equal_o
);

   generate
      if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
         $error("alu_slice4: WIDTH must lie in 1..64");
      end
      if (SEL_W != 4) begin : g_bad_sel
         $error("alu_slice4: select width must be 4");
      end
   endgenerate

   logic [WIDTH-1:0] prop;
   logic [WIDTH-1:0] gen;
   logic [WIDTH-1:0] carry_vec;
   logic             grp_gen;
   logic             grp_prop;
   logic             carry_out;

   alu_operand_gen #(.WIDTH(WIDTH)) i_operand_gen (
      .a_i    (a_i),
      .b_i    (b_i),
      .sel_i  (sel_i),
      .prop_o (prop),
      .gen_o  (gen)
   );

   alu_carry_net #(.WIDTH(WIDTH), .STYLE(CARRY_STYLE)) i_carry_net (
      .prop_i      (prop),
      .gen_i       (gen),
      .carry_i     (~carry_n_i),
      .carry_o     (carry_vec),
      .grp_gen_o   (grp_gen),
      .grp_prop_o  (grp_prop),
      .carry_out_o (carry_out)
   );

   alu_result #(.WIDTH(WIDTH)) i_result (
      .prop_i       (prop),
      .gen_i        (gen),
      .carry_i      (carry_vec),
      .logic_mode_i (logic_mode_i),
      .f_o          (f_o),
      .all_ones_o   (equal_o)
   );

   assign carry_n_o = ~carry_out;
   assign prop_n_o  = ~grp_prop;
   assign gen_n_o   = ~grp_gen;

endmodule

// File: rtl/alu_slice4_chk.sv
module alu_slice4_chk #(
   parameter int WIDTH = 4
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [3:0]       sel_i,
   input logic             logic_mode_i,
   input logic             carry_n_i,
   input logic [WIDTH-1:0] f_o,
   input logic             carry_n_o,
   input logic             prop_n_o,
   input logic             gen_n_o,
   input logic             equal_o
);

   logic [WIDTH:0] add_sum;

   always_comb begin
      add_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, ~carry_n_i};

      // R1
      a_r1_pass_a: assert (!(logic_mode_i && sel_i == 4'hF) || f_o == a_i);

      // R3
      a_r3_add: assert (!(!logic_mode_i && sel_i == 4'h9)
                        || {~carry_n_o, f_o} == add_sum);

      // R5
      a_r5_sub_borrow: assert (!(!logic_mode_i && sel_i == 4'h6 && !carry_n_i)
                               || carry_n_o == (a_i < b_i));

      // R7
      a_r7_carry_link: assert (carry_n_o == ~(~gen_n_o | (~prop_n_o & ~carry_n_i)));

      // R9
      a_r9_sub_equal: assert (!(!logic_mode_i && sel_i == 4'h6 && carry_n_i)
                              || equal_o == (a_i == b_i));
   end

endmodule

bind alu_slice4 alu_slice4_chk #(.WIDTH(WIDTH)) i_alu_slice4_chk (
   .a_i          (a_i),
   .b_i          (b_i),
   .sel_i        (sel_i),
   .logic_mode_i (logic_mode_i),
   .carry_n_i    (carry_n_i),
   .f_o          (f_o),
   .carry_n_o    (carry_n_o),
   .prop_n_o     (prop_n_o),
   .gen_n_o      (gen_n_o),
   .equal_o      (equal_o)
);

// File: tb/test_alu_slice4.sv
module test_alu_slice4;
   import alu_slice_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int n_checks = 0;
   int n_errors = 0;
   logic done = 1'b0;

   logic [3:0] a, b, s;
   logic       m, cn;
   logic [3:0] f;
   logic       cn4, pn, gn, eq;

   alu_slice4 #(.WIDTH(4), .CARRY_STYLE(CARRY_LOOKAHEAD)) i_alu_slice4 (
      .a_i(a), .b_i(b), .sel_i(s), .logic_mode_i(m), .carry_n_i(cn),
      .f_o(f), .carry_n_o(cn4), .prop_n_o(pn), .gen_n_o(gn), .equal_o(eq)
   );

   logic [15:0] ca, cb;
   logic [3:0]  cs;
   logic        ccn;
   logic [15:0] cf;
   logic [4:0]  cchain;
   logic [3:0]  ceq;
   logic [3:0]  cpn, cgn;

   assign cchain[0] = ccn;
   genvar k;
   generate
      for (k = 0; k < 4; k++) begin : g_cascade
         alu_slice4 #(.WIDTH(4), .CARRY_STYLE(CARRY_RIPPLE)) i_slice (
            .a_i(ca[4*k +: 4]), .b_i(cb[4*k +: 4]), .sel_i(cs),
            .logic_mode_i(1'b0), .carry_n_i(cchain[k]),
            .f_o(cf[4*k +: 4]), .carry_n_o(cchain[k+1]),
            .prop_n_o(cpn[k]), .gen_n_o(cgn[k]), .equal_o(ceq[k])
         );
      end
   endgenerate

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s a=%h b=%h s=%h m=%b cn=%b actual=%0h expected=%0h",
                  tag, a, b, s, m, cn, act, exp);
      end
   endtask

   function automatic logic [3:0] ref_logic(input logic [3:0] sel, input logic [3:0] x, input logic [3:0] y);
      case (sel)
         4'h0: return ~x;
         4'h1: return ~(x | y);
         4'h2: return ~x & y;
         4'h3: return 4'h0;
         4'h4: return ~(x & y);
         4'h5: return ~y;
         4'h6: return x ^ y;
         4'h7: return x & ~y;
         4'h8: return ~x | y;
         4'h9: return ~(x ^ y);
         4'hA: return y;
         4'hB: return x & y;
         4'hC: return 4'hF;
         4'hD: return x | ~y;
         4'hE: return x | y;
         default: return x;
      endcase
   endfunction

   function automatic logic [7:0] ref_pair(input logic [3:0] sel, input logic [3:0] x, input logic [3:0] y);
      case (sel)
         4'h0: return {x, 4'h0};
         4'h1: return {x | y, 4'h0};
         4'h2: return {x | ~y, 4'h0};
         4'h3: return {4'h0, 4'hF};
         4'h4: return {x, x & ~y};
         4'h5: return {x | y, x & ~y};
         4'h6: return {x, ~y};
         4'h7: return {x & ~y, 4'hF};
         4'h8: return {x, x & y};
         4'h9: return {x, y};
         4'hA: return {x | ~y, x & y};
         4'hB: return {x & y, 4'hF};
         4'hC: return {x, x};
         4'hD: return {x | y, x};
         4'hE: return {x | ~y, x};
         default: return {x, 4'hF};
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [7:0]  pr;
      logic [4:0]  sum0, sum1, sumc;
      logic        g_ref0, p_ref0;
      logic [16:0] wide;
      logic [15:0] lfsr;

      a = '0; b = '0; s = '0; m = 1'b0; cn = 1'b1;
      ca = '0; cb = '0; cs = 4'h9; ccn = 1'b1;
      g_ref0 = 1'b0; p_ref0 = 1'b0;

      // reset / idle state: zero operands, pass A, no carry
      @(negedge clk);
      check("R3 idle result", {28'b0, f}, 32'h0);
      check("R5 idle carry", {31'b0, cn4}, 32'h1);

      // R4 directed: carry polarity
      @(posedge clk); a = 4'h5; s = 4'h0; m = 1'b0; cn = 1'b1;
      @(negedge clk); check("R4 no carry passes A", {28'b0, f}, 32'h5);
      @(posedge clk); cn = 1'b0;
      @(negedge clk); check("R4 carry adds one", {28'b0, f}, 32'h6);

      // exhaustive sweep
      for (int si = 0; si < 16; si++) begin
         for (int mi = 0; mi < 2; mi++) begin
            for (int ai = 0; ai < 16; ai++) begin
               for (int bi = 0; bi < 16; bi++) begin
                  for (int ci = 1; ci >= 0; ci--) begin
                     @(posedge clk);
                     s = 4'(si); m = mi[0]; a = 4'(ai); b = 4'(bi); cn = ci[0];
                     @(negedge clk);
                     pr   = ref_pair(s, a, b);
                     sum0 = {1'b0, pr[7:4]} + {1'b0, pr[3:0]};
                     sum1 = sum0 + 5'd1;
                     sumc = cn ? sum0 : sum1;
                     if (m)
                        check("R1 R2 logic result", {28'b0, f}, {28'b0, ref_logic(s, a, b)});
                     else
                        check("R3 arith result", {28'b0, f}, {28'b0, sumc[3:0]});
                     check("R5 carry out", {31'b0, cn4}, {31'b0, ~sumc[4]});
                     check("R6 group generate", {31'b0, gn}, {31'b0, ~sum0[4]});
                     check("R7 generate or propagate", {31'b0, gn & pn}, {31'b0, ~sum1[4]});
                     check("R8 equality", {31'b0, eq}, {31'b0, (f == 4'hF)});
                     if (ci == 1) begin
                        g_ref0 = gn; p_ref0 = pn;
                     end else begin
                        check("R6 group outputs ignore carry", {30'b0, gn, pn}, {30'b0, g_ref0, p_ref0});
                     end
                     if (!m && s == 4'h6 && cn)
                        check("R9 subtract equality", {31'b0, eq}, {31'b0, a == b});
                  end
               end
            end
         end
      end

      // R10 cascade of four slices
      lfsr = 16'hACE1;
      for (int t = 0; t < 300; t++) begin
         @(posedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ca = lfsr;
         cb = (t % 7 == 0) ? lfsr : {lfsr[7:0], lfsr[15:8]} ^ 16'(t);
         if (t == 1) begin ca = 16'hFFFF; cb = 16'h0001; end
         if (t == 2) begin ca = 16'h0000; cb = 16'hFFFF; end
         cs = 4'h9; ccn = t[0];
         @(negedge clk);
         wide = {1'b0, ca} + {1'b0, cb} + {16'b0, ~ccn};
         check("R10 cascade add", {16'b0, cf}, {16'b0, wide[15:0]});
         check("R10 cascade add carry", {31'b0, cchain[4]}, {31'b0, ~wide[16]});
         @(posedge clk); cs = 4'h6; ccn = 1'b0;
         @(negedge clk);
         check("R10 cascade subtract", {16'b0, cf}, {16'b0, ca - cb});
         check("R10 cascade borrow", {31'b0, cchain[4]}, {31'b0, ca < cb});
         @(posedge clk); ccn = 1'b1;
         @(negedge clk);
         check("R10 cascade equal", {31'b0, &ceq}, {31'b0, ca == cb});
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule